// File: doc/BRIEF.md
# PLL Multiplier and Clock-Loss Control Register

This block is one 32-bit control and status word of a clock-generation unit. It stores the 12-bit feedback multiplication factor that the PLL divider uses. It shows a live flag for a missing reference clock, and it keeps a sticky copy of that flag that software clears by writing a one to it.

A simple select/write-enable port with byte strobes writes the register. Read data is formed at all times from the stored fields. Two reset inputs act differently. Power-on reset loads the factor with 0 or 4, chosen by a strap input, and clears both loss flags. Hard reset leaves all stored fields alone and only drops a pending relock pulse.

A lock input from another register blocks writes to the multiplication factor. Any write that changes the factor produces a one-cycle relock request, so the PLL re-acquires lock.

The sticky flag is a two-state machine. In LOSS_CLEAR, the detect transition, taken on any edge with the loss input high, moves it to LOSS_SEEN. In LOSS_SEEN, the clear transition, taken on a one-write to the sticky bit with no loss present, returns it to LOSS_CLEAR. In every other case the state holds.

Top module: `pllctl_reg`

## Requirements
- R1: While por_n is low, the multiplication factor is 4 if mf_por_sel is 1 and 0 otherwise; the live flag, the sticky flag and relock_req are all 0.
- R2: The multiplication factor sits at data bits 31:20 and appears on mf_out. It is written on a clock edge where sel and wr_en are both high.
- R3: Byte strobe be[3] gates data bits 31:24 (factor bits 11:4). Byte strobe be[2] gates data bits 23:16, which hold factor bits 3:0 and the sticky bit. be[1:0] affect nothing.
- R4: A write edge that changes the factor raises relock_req for exactly the following cycle.
- R5: A write whose resulting factor equals the current factor raises no relock_req.
- R6: While mf_lock is high, factor writes are ignored and raise no relock_req.
- R7: The live loss flag at data bit 18 equals clk_loss as sampled on the previous clock edge. Writes to it have no effect.
- R8: The sticky flag at data bit 17 becomes 1 on any clock edge with clk_loss high and por_n high. A loss that is present only while por_n is low leaves it 0.
- R9: Writing 1 to bit 17 under be[2] clears the sticky flag. Writing 0 leaves it unchanged.
- R10: When a loss and a clearing write occur on the same edge, the sticky flag stays 1.
- R11: hrst_n low clears relock_req at once. It leaves the factor, the live flag behaviour and the sticky flag unchanged.
- R12: All other data bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| mf_por_sel | input | 1 | Strap choosing power-on factor (1 gives 4) |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable |
| be | input | 4 | Byte strobes, be[3] for bits 31:24 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from stored fields |
| mf_lock | input | 1 | Write protection for the factor |
| clk_loss | input | 1 | Loss-of-clock detector output |
| mf_out | output | 12 | Current multiplication factor |
| relock_req | output | 1 | One-cycle request to re-acquire lock |

## Verification
A detector loss and a software clear of the sticky flag can land on the same clock edge. A table row drives clk_loss high in the same cycle as a byte-2 write carrying a one in bit 17. The bench expects the sticky bit to read 1 afterwards, and a following row without the loss expects that clear to succeed. A factor write and a hard reset can also meet: a relock pulse is raised and hrst_n is pulled low while it is high. The pulse must vanish while the new factor survives.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
    typedef enum logic [0:0] {
        LOSS_CLEAR = 1'b0,
        LOSS_SEEN  = 1'b1
    } loss_state_e;
endpackage

// File: rtl/pllctl_mf.sv
module pllctl_mf #(
    parameter int MF_W       = 12,
    parameter int MF_POR_ALT = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            hrst_n,
    input  logic            por_sel,
    input  logic            wr_hit,
    input  logic            mf_lock,
    input  logic [MF_W-1:0] wmask,
    input  logic [MF_W-1:0] wval,
    output logic [MF_W-1:0] mf_q,
    output logic            relock_q
);
    logic [MF_W-1:0] mf_next;
    logic            upd;
    logic            changed;

    assign mf_next = (wval & wmask) | (mf_q & ~wmask);
    assign upd     = wr_hit && !mf_lock;
    assign changed = upd && (mf_next != mf_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mf_q <= por_sel ? MF_W'(MF_POR_ALT) : '0;
        end else if (changed) begin
            mf_q <= mf_next;
        end
    end

    always_ff @(posedge clk or negedge por_n or negedge hrst_n) begin
        if (!por_n || !hrst_n) begin
            relock_q <= 1'b0;
        end else begin
            relock_q <= changed;
        end
    end

    // R6
    mf_lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && mf_lock) |=> $stable(mf_q));

    // R4
    relock_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        relock_q |-> (mf_q != $past(mf_q)));

    // R3
    lane_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && (wmask == '0)) |=> $stable(mf_q));
endmodule

// File: rtl/pllctl_loss.sv
module pllctl_loss
    import pllctl_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic clk_loss,
    input  logic clr_req,
    output logic live_q,
    output logic sticky
);
    loss_state_e st_q;
    loss_state_e st_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= clk_loss;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= LOSS_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LOSS_CLEAR: if (clk_loss) st_d = LOSS_SEEN;
            LOSS_SEEN:  if (clr_req && !clk_loss) st_d = LOSS_CLEAR;
            default:    st_d = LOSS_CLEAR;
        endcase
        sticky = (st_q == LOSS_SEEN);
    end

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        clk_loss |=> sticky);

    // R10
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sticky && !clr_req) |=> sticky);

    // R7
    live_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> (live_q == $past(clk_loss)));
endmodule

// File: rtl/pllctl_reg.sv
module pllctl_reg #(
    parameter int DATA_W     = 32,
    parameter int MF_W       = 12,
    parameter int MF_POR_ALT = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hrst_n,
    input  logic              mf_por_sel,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              mf_lock,
    input  logic              clk_loss,
    output logic [MF_W-1:0]   mf_out,
    output logic              relock_req
);
    localparam int MF_LSB     = DATA_W - MF_W;
    localparam int LIVE_BIT   = MF_LSB - 2;
    localparam int STICKY_BIT = MF_LSB - 3;

    logic            wr_hit;
    logic [MF_W-1:0] mf_wmask;
    logic [MF_W-1:0] mf_q;
    logic            live_q;
    logic            sticky;
    logic            clr_req;
    logic            unused_bits;

    assign wr_hit      = sel && wr_en;
    assign clr_req     = wr_hit && be[STICKY_BIT/8] && wdata[STICKY_BIT];
    assign unused_bits = ^{wdata, be};

    for (genvar i = 0; i < MF_W; i++) begin : g_lane
        localparam int LANE = (MF_LSB + i) / 8;
        assign mf_wmask[i] = be[LANE];
    end

    pllctl_mf #(
        .MF_W       (MF_W),
        .MF_POR_ALT (MF_POR_ALT)
    ) u_mf (
        .clk      (clk),
        .por_n    (por_n),
        .hrst_n   (hrst_n),
        .por_sel  (mf_por_sel),
        .wr_hit   (wr_hit),
        .mf_lock  (mf_lock),
        .wmask    (mf_wmask),
        .wval     (wdata[DATA_W-1:MF_LSB]),
        .mf_q     (mf_q),
        .relock_q (relock_req)
    );

    pllctl_loss u_loss (
        .clk      (clk),
        .por_n    (por_n),
        .clk_loss (clk_loss),
        .clr_req  (clr_req),
        .live_q   (live_q),
        .sticky   (sticky)
    );

    always_comb begin
        rdata                       = '0;
        rdata[DATA_W-1:MF_LSB]      = mf_q;
        rdata[LIVE_BIT]             = live_q;
        rdata[STICKY_BIT]           = sticky;
    end

    assign mf_out = mf_q;

    // R11
    hrst_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !hrst_n |-> !relock_req);

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rdata & ~((DATA_W'(1) << LIVE_BIT) | (DATA_W'(1) << STICKY_BIT)
                   | ({DATA_W{1'b1}} << MF_LSB))) == '0);
endmodule

// File: tb/pllctl_reg_tb.sv
module pllctl_reg_tb;
    logic        clk = 1'b0;
    logic        por_n, hrst_n, mf_por_sel, sel, wr_en, mf_lock, clk_loss;
    logic [3:0]  be;
    logic [31:0] wdata, rdata;
    logic [11:0] mf_out;
    logic        relock_req;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pllctl_reg u_dut (
        .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .mf_por_sel(mf_por_sel),
        .sel(sel), .wr_en(wr_en), .be(be), .wdata(wdata), .rdata(rdata),
        .mf_lock(mf_lock), .clk_loss(clk_loss), .mf_out(mf_out),
        .relock_req(relock_req)
    );

    // {wr, be, wdata, lock, loss, exp_mf, exp_relock, exp_sticky, exp_live}
    localparam logic [53:0] VEC [12] = '{
        {1'b1, 4'hF, 32'h12300000, 1'b0, 1'b0, 12'h123, 1'b1, 1'b0, 1'b0}, // R2 R4
        {1'b1, 4'hF, 32'h12300000, 1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 1'b0}, // R5
        {1'b1, 4'h8, 32'hAB000000, 1'b0, 1'b0, 12'hAB3, 1'b1, 1'b0, 1'b0}, // R3
        {1'b1, 4'h4, 32'h00500000, 1'b0, 1'b0, 12'hAB5, 1'b1, 1'b0, 1'b0}, // R3
        {1'b1, 4'hF, 32'hFFF00000, 1'b1, 1'b0, 12'hAB5, 1'b0, 1'b0, 1'b0}, // R6
        {1'b0, 4'h0, 32'h00000000, 1'b0, 1'b1, 12'hAB5, 1'b0, 1'b1, 1'b1}, // R8 R7
        {1'b0, 4'h0, 32'h00000000, 1'b0, 1'b0, 12'hAB5, 1'b0, 1'b1, 1'b0}, // R7
        {1'b1, 4'hF, 32'hAB540001, 1'b0, 1'b0, 12'hAB5, 1'b0, 1'b1, 1'b0}, // R9 R12
        {1'b1, 4'h2, 32'h00020000, 1'b0, 1'b0, 12'hAB5, 1'b0, 1'b1, 1'b0}, // R3
        {1'b1, 4'h4, 32'h00520000, 1'b0, 1'b0, 12'hAB5, 1'b0, 1'b0, 1'b0}, // R9
        {1'b1, 4'h4, 32'h00520000, 1'b0, 1'b1, 12'hAB5, 1'b0, 1'b1, 1'b1}, // R10
        {1'b1, 4'h4, 32'h00520000, 1'b0, 1'b0, 12'hAB5, 1'b0, 1'b0, 1'b0}  // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        por_n = 1'b0; hrst_n = 1'b1; mf_por_sel = 1'b0; sel = 1'b0; wr_en = 1'b0;
        be = 4'h0; wdata = '0; mf_lock = 1'b0; clk_loss = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1; clk_loss = 1'b0;
        cyc();
        chk("R1 mf", 32'(mf_out), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 relock", 32'(relock_req), 32'h0);
        chk("R8 no sticky from por-time loss", 32'(rdata[17]), 32'h0);

        for (int k = 0; k < 12; k++) begin
            sel = VEC[k][53]; wr_en = VEC[k][53]; be = VEC[k][52:49];
            wdata = VEC[k][48:17]; mf_lock = VEC[k][16]; clk_loss = VEC[k][15];
            cyc();
            chk($sformatf("R2 row%0d mf", k), 32'(mf_out), 32'(VEC[k][14:3]));
            chk($sformatf("R4 R5 row%0d relock", k), 32'(relock_req), 32'(VEC[k][2]));
            chk($sformatf("R12 row%0d rdata", k), rdata,
                (32'(VEC[k][14:3]) << 20) | (32'(VEC[k][0]) << 18) | (32'(VEC[k][1]) << 17));
        end
        sel = 1'b0; wr_en = 1'b0; mf_lock = 1'b0; clk_loss = 1'b0;

        // hard reset against a pending relock pulse
        sel = 1'b1; wr_en = 1'b1; be = 4'hF; wdata = 32'h77700000; clk_loss = 1'b1;
        cyc();
        sel = 1'b0; wr_en = 1'b0; clk_loss = 1'b0;
        chk("R4 relock raised", 32'(relock_req), 32'h1);
        hrst_n = 1'b0;
        #1;
        chk("R11 relock dropped", 32'(relock_req), 32'h0);
        @(negedge clk);
        cyc();
        chk("R11 mf kept", 32'(mf_out), 32'h777);
        chk("R11 sticky kept", 32'(rdata[17]), 32'h1);
        chk("R7 live during hard reset", 32'(rdata[18]), 32'h0);
        hrst_n = 1'b1;

        // pulse width
        sel = 1'b1; wr_en = 1'b1; be = 4'hF; wdata = 32'h88800000;
        cyc();
        sel = 1'b0; wr_en = 1'b0;
        chk("R4 pulse high", 32'(relock_req), 32'h1);
        cyc();
        chk("R4 pulse one cycle", 32'(relock_req), 32'h0);

        // second power-on reset with the alternate strap
        mf_por_sel = 1'b1; por_n = 1'b0;
        cyc();
        chk("R1 alt mf", 32'(mf_out), 32'h4);
        chk("R1 alt rdata", rdata, 32'h00400000);
        por_n = 1'b1;
        cyc();
        chk("R1 alt kept", 32'(mf_out), 32'h4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule